// File: doc/BRIEF.md
# Carry-Save Radix-2 Montgomery Multiplier

The block computes the Montgomery product X·Y·2^(-W) mod M for W-bit operands, where M is odd and X, Y are already below M. It consumes one multiplier bit per clock cycle. X, Y and M stay in plain binary. Only the running partial sum is redundant: it is held as a sum vector and a carry vector.

Each iteration adds two three-input terms, the selected multiple of Y and then the selected multiple of M. Each addition is a row of independent full adders, so the step's combinational depth does not depend on W. When all W iterations are done, one extra cycle adds the two vectors with a carry-propagate adder and subtracts M once if needed. The result lies in [0, M), so it can go straight back in as X or Y of the next multiplication, for example inside an exponentiation loop.

The block is driven by a start / busy / done handshake. All operands are presented in parallel on the cycle that start is taken, and the result comes back on a parallel output.

Top module: `csa_mont_mul`

## Requirements
- R1: For odd M and X, Y < M, the `result` presented with `done` equals X·Y·2^(-WIDTH) mod M and is strictly below M.
- R2: `done` is high for exactly one cycle, at the WIDTH+1-th rising edge after the edge that sampled `start` while idle.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high.
- R4: `start` and operand changes while `busy` is high have no effect. They change neither the pending result nor its timing, and they produce no extra `done`.
- R5: `result` keeps its value between two `done` pulses.
- R6: Every iteration produces an even three-operand total before the halving shift, and no carry is lost at the top of the redundant vectors.
- R7: After reset, `busy`, `done` and `result` are all zero.
- R8: A zero operand gives a zero result, and an operand of M−1 is handled like any other value below M.
- R9: A result fed back as the X input of a following multiplication with the same M gives the correct Montgomery product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when sampled high while idle |
| x_in | input | WIDTH | Multiplier X, below M |
| y_in | input | WIDTH | Multiplicand Y, below M |
| m_in | input | WIDTH | Odd modulus M |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | WIDTH | X·Y·2^(-WIDTH) mod M |

## Verification
The hardest condition to reach is a late start pulse that arrives with different operands while a run is in flight. It must leave both the pending result and the done timing untouched. The stimulus reaches it by toggling every operand input right after each accepted start. A dedicated run also pulses start mid-iteration and then watches an idle window for a stray done. The final conditional subtraction is exercised at its edges with the largest odd modulus, the smallest moduli (1 and 3), operands of M−1, and chained runs whose inputs are earlier results.

// File: rtl/mm_pkg.sv
package mm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_CONV = 2'd2
   } mm_state_e;

   function automatic int mm_cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mm_csa_row.sv
module mm_csa_row #(
   parameter int N = 8
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic [N-1:0] c_i,
   output logic [N-1:0] sum_o,
   output logic [N-1:0] cy_o
);

   if (N < 1) begin : g_bad_n
      $error("mm_csa_row: N must be positive");
   end

   // One full adder per bit; no signal crosses between bit positions.
   for (genvar k = 0; k < N; k++) begin : g_fa
      assign sum_o[k] = a_i[k] ^ b_i[k] ^ c_i[k];
      assign cy_o[k]  = (a_i[k] & b_i[k]) | (a_i[k] & c_i[k]) | (b_i[k] & c_i[k]);
   end

endmodule

// File: rtl/mm_step.sv
module mm_step #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH+1:0] ss_i,
   input  logic [WIDTH+1:0] sc_i,
   input  logic             xbit_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic [WIDTH-1:0] m_i,
   output logic [WIDTH+1:0] ss_o,
   output logic [WIDTH+1:0] sc_o,
   output logic             lsb_o,
   output logic             top_o
);

   localparam int SW = WIDTH + 2;

   logic [SW-1:0] add_y;
   logic [SW-1:0] s1;
   logic [SW-1:0] c1;
   logic          qbit;
   logic [SW:0]   a2;
   logic [SW:0]   b2;
   logic [SW:0]   add_m;
   logic [SW:0]   s2;
   logic [SW:0]   c2;

   assign add_y = xbit_i ? {2'b00, y_i} : '0;

   mm_csa_row #(.N(SW)) u_row_y (
      .a_i   (ss_i),
      .b_i   (sc_i),
      .c_i   (add_y),
      .sum_o (s1),
      .cy_o  (c1)
   );

   // Carry vector has weight two, so bit zero of the total is s1[0].
   assign qbit  = s1[0];
   assign a2    = {1'b0, s1};
   assign b2    = {c1, 1'b0};
   assign add_m = qbit ? {3'b000, m_i} : '0;

   mm_csa_row #(.N(SW+1)) u_row_m (
      .a_i   (a2),
      .b_i   (b2),
      .c_i   (add_m),
      .sum_o (s2),
      .cy_o  (c2)
   );

   // Halve: sum vector drops its zero LSB, carry vector loses its weight two.
   assign ss_o  = s2[SW:1];
   assign sc_o  = c2[SW-1:0];
   assign lsb_o = s2[0];
   assign top_o = c2[SW];

endmodule

// File: rtl/mm_final.sv
module mm_final #(
   parameter int WIDTH        = 64,
   parameter int REDUCE_STYLE = 0
) (
   input  logic [WIDTH+1:0] ss_i,
   input  logic [WIDTH+1:0] sc_i,
   input  logic [WIDTH-1:0] m_i,
   output logic [WIDTH-1:0] res_o,
   output logic [1:0]       hi_o
);

   localparam int FW = WIDTH + 3;

   logic [FW-1:0] full;

   assign full = {1'b0, ss_i} + {1'b0, sc_i};
   assign hi_o = full[FW-1:FW-2];

   if (REDUCE_STYLE == 0) begin : g_compare
      logic [WIDTH-1:0] diff;
      logic             ge;
      assign ge    = full[WIDTH:0] >= {1'b0, m_i};
      assign diff  = full[WIDTH-1:0] - m_i;
      assign res_o = ge ? diff : full[WIDTH-1:0];
   end else if (REDUCE_STYLE == 1) begin : g_borrow
      logic [WIDTH:0] ext;
      assign ext   = full[WIDTH:0] - {1'b0, m_i};
      assign res_o = ext[WIDTH] ? full[WIDTH-1:0] : ext[WIDTH-1:0];
   end else begin : g_bad_style
      $error("mm_final: REDUCE_STYLE must be 0 or 1");
      assign res_o = '0;
   end

endmodule

// File: rtl/csa_mont_mul.sv
module csa_mont_mul
   import mm_pkg::*;
#(
   parameter int WIDTH        = 64,
   parameter int REDUCE_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   input  logic [WIDTH-1:0] m_in,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);

   localparam int            SW   = WIDTH + 2;
   localparam int            CW   = mm_cnt_width(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("csa_mont_mul: WIDTH must be at least 2");
   end

   mm_state_e        state;
   logic [WIDTH-1:0] x_q;
   logic [WIDTH-1:0] y_q;
   logic [WIDTH-1:0] m_q;
   logic [SW-1:0]    ss_q;
   logic [SW-1:0]    sc_q;
   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] res_q;
   logic             done_q;

   logic [SW-1:0]    ss_nx;
   logic [SW-1:0]    sc_nx;
   logic             step_lsb;
   logic             step_top;
   logic [WIDTH-1:0] res_nx;
   logic [1:0]       conv_hi;

   mm_step #(.WIDTH(WIDTH)) u_step (
      .ss_i   (ss_q),
      .sc_i   (sc_q),
      .xbit_i (x_q[0]),
      .y_i    (y_q),
      .m_i    (m_q),
      .ss_o   (ss_nx),
      .sc_o   (sc_nx),
      .lsb_o  (step_lsb),
      .top_o  (step_top)
   );

   mm_final #(.WIDTH(WIDTH), .REDUCE_STYLE(REDUCE_STYLE)) u_final (
      .ss_i  (ss_q),
      .sc_i  (sc_q),
      .m_i   (m_q),
      .res_o (res_nx),
      .hi_o  (conv_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         x_q    <= '0;
         y_q    <= '0;
         m_q    <= '0;
         ss_q   <= '0;
         sc_q   <= '0;
         cnt    <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  x_q   <= x_in;
                  y_q   <= y_in;
                  m_q   <= m_in;
                  ss_q  <= '0;
                  sc_q  <= '0;
                  cnt   <= '0;
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin
               ss_q <= ss_nx;
               sc_q <= sc_nx;
               x_q  <= x_q >> 1;
               cnt  <= cnt + 1'b1;
               if (cnt == LAST) begin
                  state <= ST_CONV;
               end
            end
            ST_CONV: begin
               res_q  <= res_nx;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign done   = done_q;
   assign result = res_q;

   // R1: the reduced output is below the modulus in use.
   a_r1_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result < m_q));

   // R1: the converted total stays below 2^(WIDTH+1).
   a_r1_conv_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |-> (conv_hi == 2'b00));

   // R2: done follows the conversion cycle and lasts one cycle.
   a_r2_conv_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |=> done);

   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: busy and done never overlap; an accepted start raises busy.
   a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R4: start during a run leaves the latched operands alone.
   a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(m_q) && $stable(y_q)));

   // R5: the output only moves with done.
   a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R6: every step total is even and nothing spills past the top bit.
   a_r6_even_total: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (!step_lsb && !step_top));

endmodule

// File: tb/csa_mont_mul_bench.sv
module csa_mont_mul_bench;

   localparam int W  = 64;
   localparam int TW = W + 2;

   logic         clk;
   logic         rst_n;
   logic         start;
   logic [W-1:0] x_in;
   logic [W-1:0] y_in;
   logic [W-1:0] m_in;
   logic         busy;
   logic         done;
   logic [W-1:0] result;

   int checks;
   int errors;
   int cyc;
   bit finished;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   int           stc_q[$];

   logic [W-1:0] last_res;
   bit           moved;

   csa_mont_mul #(.WIDTH(W)) u_csa_mont_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .x_in   (x_in),
      .y_in   (y_in),
      .m_in   (m_in),
      .busy   (busy),
      .done   (done),
      .result (result)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   initial cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [W-1:0] rand_w();
      logic [W-1:0] r;
      r = '0;
      for (int k = 0; k < (W + 31) / 32; k++) begin
         r = (r << 32) | W'($urandom);
      end
      return r;
   endfunction

   // Product mod M, then W halvings modulo the odd M.
   function automatic logic [W-1:0] ref_mont(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic [W-1:0] m);
      logic [2*W-1:0] p;
      logic [TW-1:0]  t;
      p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
      t = TW'(p % {{W{1'b0}}, m});
      for (int k = 0; k < W; k++) begin
         if (t[0]) t = (t + {2'b00, m}) >> 1;
         else      t = t >> 1;
      end
      return t[W-1:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Monitor / scoreboard.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "done without pending start", W'(1), W'(0));
            end else begin
               logic [W-1:0] e;
               string        tg;
               int           sc;
               e  = exp_q.pop_front();
               tg = tag_q.pop_front();
               sc = stc_q.pop_front();
               check(result == e, "R1", tg, result, e);
               check((cyc - sc) == W + 2, "R2", "done latency",
                     W'(cyc - sc), W'(W + 2));
               check(!busy, "R3", "busy low with done", W'(busy), W'(0));
               check(!moved, "R5", "result moved between done pulses",
                     W'(moved), W'(0));
            end
            last_res = result;
            moved    = 1'b0;
         end else if (result !== last_res) begin
            moved = 1'b1;
         end
      end
   end

   task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [W-1:0] m, input string tag,
                         input bit poke);
      @(negedge clk);
      while (busy) @(negedge clk);
      x_in  = x;
      y_in  = y;
      m_in  = m;
      start = 1'b1;
      exp_q.push_back(ref_mont(x, y, m));
      tag_q.push_back(tag);
      stc_q.push_back(cyc);
      @(negedge clk);
      start = 1'b0;
      // R4: operands change right after acceptance.
      x_in  = rand_w();
      y_in  = rand_w();
      m_in  = rand_w();
      check(busy, "R3", "busy after accepted start", W'(busy), W'(1));
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         x_in  = rand_w();
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
   endtask

   initial begin
      finished = 1'b0;
      repeat (200000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", '0, '0);
      finish_run();
   end

   initial begin
      logic [W-1:0] m;
      logic [W-1:0] xr;
      logic [W-1:0] yr;
      logic [W-1:0] mx;
      checks   = 0;
      errors   = 0;
      last_res = '0;
      moved    = 1'b0;
      rst_n    = 1'b0;
      start    = 1'b0;
      x_in     = '0;
      y_in     = '0;
      m_in     = '0;
      repeat (3) @(negedge clk);
      // R7: reset values.
      check(!busy, "R7", "busy in reset", W'(busy), '0);
      check(!done, "R7", "done in reset", W'(done), '0);
      check(result == '0, "R7", "result in reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && result == '0, "R7", "state after reset",
            result, '0);

      mx = '1;
      // R8: zero and M-1 corners.
      run_op('0, mx - 1, mx, "R8 x zero", 1'b0);
      run_op(mx - 1, '0, mx, "R8 y zero", 1'b0);
      run_op(mx - 1, mx - 1, mx, "R8 both M-1 max modulus", 1'b0);
      run_op(W'(1), W'(1), mx, "R8 ones", 1'b0);
      run_op('0, '0, W'(1), "R8 modulus one", 1'b0);
      run_op(W'(2), W'(2), W'(3), "R8 modulus three", 1'b0);
      run_op(W'(2), W'(1), W'(3), "R8 modulus three b", 1'b0);
      m = rand_w() | W'(1);
      run_op(m - 1, W'(1), m, "R8 M-1 times one", 1'b0);

      // R1: random odd moduli.
      for (int i = 0; i < 20; i++) begin
         m  = rand_w() | W'(1);
         xr = rand_w() % m;
         yr = rand_w() % m;
         run_op(xr, yr, m, "R1 random", 1'b0);
      end

      // R4: late start pulse during a run, then an idle window.
      m  = rand_w() | W'(1);
      xr = rand_w() % m;
      yr = rand_w() % m;
      run_op(xr, yr, m, "R4 start while busy", 1'b1);
      begin
         bit extra;
         extra = 1'b0;
         repeat (W + 6) begin
            @(negedge clk);
            if (done || busy) extra = 1'b1;
         end
         check(!extra, "R4", "activity after ignored start", W'(extra), '0);
      end

      // R9: chained results as the next X.
      m  = rand_w() | W'(1);
      yr = rand_w() % m;
      run_op(rand_w() % m, yr, m, "R9 chain seed", 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         run_op(last_res, yr, m, "R9 chained", 1'b0);
      end

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R2", "pending results left",
            W'(exp_q.size()), '0);
      finish_run();
   end

endmodule